// File: doc/BRIEF.md
# Two-Output Interrupt Controller with Fast-Line Steering

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Each source has an enable bit and a steering bit. A source that is asserting and enabled drives the normal line when its steering bit is 0, and drives the fast line when its steering bit is 1. Software looks at one status register per line to see which sources are behind the request.

The enable mask is never written directly. Software writes ones to a set register to turn sources on and writes ones to a clear register to turn them off, so two drivers never disturb each other's bits. The usual start-up sequence writes all ones to the clear register. Sources carry fixed roles: 0 is the timer, 1 and 2 are the serial ports, 3 is USB, 4 and 5 are the external pins, 6 to 8 are the PCI lines, 9 is the switch, and 10 to 31 are reserved. The controller itself treats every source the same way.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After synchronous reset, every enable bit and steering bit is 0, both interrupt outputs are 0, and rdata is 0.
- R2: A write to byte offset 0x08 sets the enable bit of each source whose bit in wdata is 1 and leaves the other enables as they were. A read of 0x08 returns the enable mask.
- R3: A write to byte offset 0x0C clears the enable bit of each source whose bit in wdata is 1 and leaves the other enables as they were.
- R4: Offset 0x10 is a read/write steering register. Bit n set to 1 steers source n to fiq_o, and 0 steers it to irq_o.
- R5: A read of offset 0x00 returns src_in & enable & ~steer. A read of offset 0x04 returns src_in & enable & steer. Both use the values present at the read edge.
- R6: irq_o is the OR of the normal status bits, and fiq_o is the OR of the fast status bits. Both are registered and follow a change one clock later.
- R7: Writes to 0x00, 0x04 and to any offset not listed above change nothing. Reads of 0x0C and of unlisted offsets, including misaligned ones, return 0.
- R8: rdata is loaded on the clock edge where rd_en is high and holds its value otherwise. A read and a write in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe; data appears one cycle later |
| addr | input | ADDR_W (8) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_in | input | 32 | Raw level interrupt sources, bit n = source n |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
A read and a write can land on the same clock edge. When both target the enable register, the read must return the mask from before the update. A source change and a set or clear write can also share an edge. In that case the outputs and status registers must follow the old mask for one cycle and the new mask after that. Both cases are produced on purpose by directed strobes and by random traffic that often raises rd_en and wr_en together. A bench model updates its state only after it has computed the values due at that edge, and every rdata and output sample is compared with that model.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned OFS_IRQ_STAT = 'h00;
  localparam int unsigned OFS_FIQ_STAT = 'h04;
  localparam int unsigned OFS_EN_SET   = 'h08;
  localparam int unsigned OFS_EN_CLR   = 'h0C;
  localparam int unsigned OFS_STEER    = 'h10;

  typedef enum logic [2:0] {
    SEL_IRQ_STAT,
    SEL_FIQ_STAT,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_STEER,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_IRQ_STAT))      sel = SEL_IRQ_STAT;
    else if (addr == ADDR_W'(OFS_FIQ_STAT)) sel = SEL_FIQ_STAT;
    else if (addr == ADDR_W'(OFS_EN_SET))   sel = SEL_EN_SET;
    else if (addr == ADDR_W'(OFS_EN_CLR))   sel = SEL_EN_CLR;
    else if (addr == ADDR_W'(OFS_STEER))    sel = SEL_STEER;
    else                                    sel = SEL_NONE;
  end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] en_q,
  output logic [SRC_W-1:0] steer_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      steer_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_EN_SET: en_q    <= en_q | wdata;
        SEL_EN_CLR: en_q    <= en_q & ~wdata;
        SEL_STEER:  steer_q <= wdata;
        default:    ;
      endcase
    end
  end

  // R1
  regs_reset_chk: assert property (@(posedge clk) rst |=> (en_q == '0) && (steer_q == '0));
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata)) &&
      ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_EN_CLR) |=> ((en_q & $past(wdata)) == '0) &&
      ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (sel == SEL_EN_SET || sel == SEL_EN_CLR)) |=> $stable(en_q));
  // R4
  steer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == SEL_STEER) |=> $stable(steer_q));
endmodule

// File: rtl/icu_route.sv
module icu_route #(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_in,
  input  logic [SRC_W-1:0] en_q,
  input  logic [SRC_W-1:0] steer_q,
  output logic [SRC_W-1:0] irq_stat,
  output logic [SRC_W-1:0] fiq_stat,
  output logic             irq_o,
  output logic             fiq_o
);
  for (genvar n = 0; n < SRC_W; n++) begin : g_src
    logic live;
    assign live        = src_in[n] & en_q[n];
    assign irq_stat[n] = live & ~steer_q[n];
    assign fiq_stat[n] = live & steer_q[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
    end
  end

  // R1
  out_reset_chk: assert property (@(posedge clk) rst |=> !irq_o && !fiq_o);
  // R4
  stat_disjoint_chk: assert property (@(posedge clk) disable iff (rst) (irq_stat & fiq_stat) == '0);
  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == ($past(src_in & en_q & ~steer_q) != '0));
  // R6
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fiq_o == ($past(src_in & en_q & steer_q) != '0));
endmodule

// File: rtl/icu_rdmux.sv
module icu_rdmux
  import icu_pkg::*;
#(
  parameter int SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [SRC_W-1:0] irq_stat,
  input  logic [SRC_W-1:0] fiq_stat,
  input  logic [SRC_W-1:0] en_q,
  input  logic [SRC_W-1:0] steer_q,
  output logic [SRC_W-1:0] rdata
);
  logic [SRC_W-1:0] rd_next;

  always_comb begin
    case (sel)
      SEL_IRQ_STAT: rd_next = irq_stat;
      SEL_FIQ_STAT: rd_next = fiq_stat;
      SEL_EN_SET:   rd_next = en_q;
      SEL_STEER:    rd_next = steer_q;
      default:      rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata));
  // R7
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel == SEL_NONE || sel == SEL_EN_CLR)) |=> rdata == '0);
  // R5
  rd_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_IRQ_STAT) |=> rdata == $past(irq_stat));
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import icu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  wdata,
  output logic [SRC_W-1:0]  rdata,
  input  logic [SRC_W-1:0]  src_in,
  output logic              irq_o,
  output logic              fiq_o
);
  reg_sel_e         sel;
  logic [SRC_W-1:0] en_q, steer_q, irq_stat, fiq_stat;

  icu_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

  icu_regs #(.SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .en_q(en_q), .steer_q(steer_q)
  );

  icu_route #(.SRC_W(SRC_W)) u_route (
    .clk(clk), .rst(rst), .src_in(src_in), .en_q(en_q), .steer_q(steer_q),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  icu_rdmux #(.SRC_W(SRC_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .irq_stat(irq_stat),
    .fiq_stat(fiq_stat), .en_q(en_q), .steer_q(steer_q), .rdata(rdata)
  );
endmodule

// File: tb/irq_fiq_ctrl_test.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, src_in = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_en = '0, m_steer = '0, m_rdata = '0;
  logic        m_irq = 1'b0, m_fiq = 1'b0;

  always #10 clk = ~clk;

  irq_fiq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] model_read(logic [7:0] a, logic [31:0] s);
    case (a)
      8'h00:   return s & m_en & ~m_steer;
      8'h04:   return s & m_en & m_steer;
      8'h08:   return m_en;
      8'h10:   return m_steer;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R5";
      8'h08:        return "R2";
      8'h10:        return "R4";
      default:      return "R7";
    endcase
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive at a negedge, pass one posedge, return at the following negedge after checking.
  task automatic step(logic w, logic r, logic [7:0] a, logic [31:0] d, logic [31:0] s,
                      string req = "");
    wr_en = w; rd_en = r; addr = a; wdata = d; src_in = s;
    if (r) m_rdata = model_read(a, s);
    m_irq = |(s & m_en & ~m_steer);
    m_fiq = |(s & m_en & m_steer);
    if (w) begin
      case (a)
        8'h08: m_en = m_en | d;
        8'h0C: m_en = m_en & ~d;
        8'h10: m_steer = d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check32((req != "") ? req : (r ? tag_for(a) : "R8"), rdata, m_rdata);
    check32("R6", {31'b0, irq_o}, {31'b0, m_irq});
    check32("R6", {31'b0, fiq_o}, {31'b0, m_fiq});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    src_in = 32'hFFFF_FFFF;
    @(negedge clk);
    // R1 reset state
    check32("R1", rdata, 32'h0);
    check32("R1", {30'b0, irq_o, fiq_o}, 32'h0);
    rst = 1'b0;
    step(0, 1, 8'h08, 0, 32'hFFFF_FFFF, "R1");
    step(0, 1, 8'h10, 0, 32'hFFFF_FFFF, "R1");

    // R2 set semantics
    step(1, 0, 8'h08, 32'h0000_00F0, 32'h0);
    step(1, 0, 8'h08, 32'h0000_0003, 32'h0);
    step(0, 1, 8'h08, 0, 32'h0, "R2");
    // R3 clear semantics
    step(1, 0, 8'h0C, 32'h0000_0011, 32'h0);
    step(0, 1, 8'h08, 0, 32'h0, "R3");
    // R4 steering readback and routing
    step(1, 0, 8'h10, 32'hA5A5_0F0F, 32'h0);
    step(0, 1, 8'h10, 0, 32'h0, "R4");
    step(0, 1, 8'h00, 0, 32'hFFFF_FFFF, "R5");
    step(0, 1, 8'h04, 0, 32'hFFFF_FFFF, "R5");
    // R8 read and write on the same edge return pre-write value
    step(1, 1, 8'h08, 32'hFFFF_0000, 32'h0000_0100, "R8");
    step(0, 1, 8'h08, 0, 32'h0000_0100, "R8");
    step(0, 0, 8'h00, 0, 32'h0, "R8");
    // R7 ignored writes and unmapped reads
    step(1, 0, 8'h00, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 8'h04, 32'h0, 32'h0);
    step(1, 0, 8'h14, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 8'h09, 32'hFFFF_FFFF, 32'h0);
    step(0, 1, 8'h08, 0, 32'h0, "R7");
    step(0, 1, 8'h10, 0, 32'h0, "R7");
    step(0, 1, 8'h14, 0, 32'h0, "R7");
    step(0, 1, 8'h0C, 0, 32'h0, "R7");
    step(0, 1, 8'h0A, 0, 32'h0, "R7");
    // R3 full-mask disable as at start-up
    step(1, 1, 8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    step(0, 1, 8'h00, 0, 32'hFFFF_FFFF, "R3");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d, s;
      logic w, r;
      case ($urandom_range(0, 7))
        0, 1: a = 8'h08;
        2:    a = 8'h0C;
        3:    a = 8'h10;
        4:    a = 8'h00;
        5:    a = 8'h04;
        6:    a = 8'(($urandom_range(5, 63)) << 2);
        default: a = 8'($urandom_range(0, 255));
      endcase
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & $urandom();
      s = $urandom() & $urandom();
      w = ($urandom_range(0, 2) != 0);
      r = ($urandom_range(0, 2) != 0);
      step(w, r, a, d, s);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule